// File: doc/BRIEF.md
# Fused Multiply-Add Operand Alignment Stage

This stage sits between the carry-save outputs of a multiplier array and the final 4-2 compressor of a partially overlapped fused multiply-add datapath. It compares the product exponent with the addend exponent and sorts the operation into one of six cases. It then aligns the terms over a double-width span. A span is the operand placed in the top MW bits with MW zero bits below it. When the product is larger, only the addend moves right. Otherwise the sum and carry vectors move right together.

The same shifters serve a standalone addition. In that mode a second operand takes the place of the sum vector and the carry term is forced to zero. One thermometer mask, ones below the carry point, is used for two things. It selects the bits that feed the sticky bit, and it sets the weight of the rounding term, which is the multiplier rounding value moved up to the carry point. The results are registered behind a one-deep valid stage. The four terms go on to the compressor, and the final addition is outside this block.

The output stage is a two-state machine. In IDLE no result is valid. In HOLD a result is valid. The transition LOAD (any state to HOLD) is taken on `in_valid`. The transition DRAIN (HOLD to IDLE) is taken when `in_valid` is low. The transition WAIT keeps IDLE while `in_valid` is low.

Top module: `fma_align_unit`

## Requirements
- R1: After reset `out_valid`, `case_code`, all terms and `sticky` are 0. A vector taken with `in_valid` high appears on the outputs after the next rising edge with `out_valid` high. A cycle with `in_valid` low gives `out_valid` low one edge later.
- R2: With d = `exp_prod` - `exp_addend` and near meaning |d| <= 2, `case_code` is set as follows. Addition: 1 if d > 0, otherwise 2. Subtraction: 3 if d > 0 and near; 4 if d > 0 and not near; 5 if d <= 0 and near; 6 if d <= 0 and not near.
- R3: When d > 0, `term_addend` is the addend span shifted right by min(d, 2·MW). `term_sum` and `term_carry` are the unshifted spans.
- R4: When d <= 0, `term_sum` and `term_carry` are their spans shifted right by min(-d, 2·MW). `term_addend` is unshifted.
- R5: In effective subtraction the shifted terms are bitwise inverted over the full 2·MW width. That is the addend when d > 0, and the sum and carry when d <= 0. Unshifted terms are never inverted.
- R6: `term_round` equals `mul_rnd` shifted left by cp. cp = MW when d > 0; otherwise cp = max(MW + d, 0).
- R7: `sticky` is 1 when any aligned, non-inverted term has a 1 below bit cp, or when any operand bit was shifted past bit 0.
- R8: With `fused_mode` = 0, `addend_d` takes the place of the sum vector and `term_carry` is 0.
- R9: With `fused_mode` = 1, `addend_d` has no effect on any output.
- R10: A distance beyond 2·MW acts as 2·MW. The moved term becomes all zeros (all ones if inverted), and every nonzero bit it held sets `sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector present |
| fused_mode | input | 1 | 1 = fused multiply-add, 0 = standalone add |
| eff_sub | input | 1 | Effective subtraction |
| exp_prod | input | EW | Product exponent (exponent of d in add mode) |
| exp_addend | input | EW | Addend exponent |
| sum_vec | input | MW | Multiplier sum vector |
| carry_vec | input | MW | Multiplier carry vector |
| addend_c | input | MW | Addend significand |
| addend_d | input | MW | Second add operand, used only in add mode |
| mul_rnd | input | 2 | Multiplier rounding value, 0 to 3 |
| out_valid | output | 1 | Registered result valid |
| case_code | output | 3 | Alignment case, 1 to 6 |
| term_sum | output | 2·MW | Aligned sum term |
| term_carry | output | 2·MW | Aligned carry term |
| term_addend | output | 2·MW | Aligned addend term |
| term_round | output | 2·MW | Weighted rounding term |
| sticky | output | 1 | OR of bits below the carry point |

## Verification
With MW = 6 and a 4-bit exponent, the bench sweeps every pair of exponents in both modes and for both effective operations. This covers all six cases and every distance from zero through the near boundary at 2 and up to past the span. Distances of 1 and 2 separate the near mux path from the full shifter. Distances above 12 exercise saturation and the case where every bit goes to sticky. The operands change from vector to vector, so inversion, sticky and rounding weight are seen with many bit patterns. A repeated fused vector with a changed `addend_d` shows that operand is ignored.

// File: rtl/fmaal_pkg.sv
package fmaal_pkg;
    typedef enum logic [2:0] {
        CASE_NONE      = 3'd0,
        CASE_ADD_PGT   = 3'd1,
        CASE_ADD_PLE   = 3'd2,
        CASE_SUB_PNEAR = 3'd3,
        CASE_SUB_PFAR  = 3'd4,
        CASE_SUB_CNEAR = 3'd5,
        CASE_SUB_CFAR  = 3'd6
    } align_case_e;

    typedef enum logic {
        ST_IDLE,
        ST_HOLD
    } out_state_e;
endpackage

// File: rtl/fmaal_classify.sv
module fmaal_classify
    import fmaal_pkg::*;
#(
    parameter int EW        = 11,
    parameter int MW        = 53,
    parameter int CLOSE_THR = 2,
    parameter int SHW       = 7
) (
    input  logic           eff_sub,
    input  logic [EW-1:0]  exp_prod,
    input  logic [EW-1:0]  exp_addend,
    output align_case_e    case_o,
    output logic           prod_larger,
    output logic           near,
    output logic [SHW-1:0] shamt
);
    localparam int SPAN = 2 * MW;

    logic signed [EW:0] diff;
    logic        [31:0] mag;

    always_comb begin
        diff        = $signed({1'b0, exp_prod}) - $signed({1'b0, exp_addend});
        prod_larger = (diff > 0);
        mag         = prod_larger ? 32'(diff) : 32'(-diff);
        near        = (mag <= 32'(CLOSE_THR));
        shamt       = (mag > 32'(SPAN)) ? SHW'(SPAN) : SHW'(mag);
        if (!eff_sub)
            case_o = prod_larger ? CASE_ADD_PGT : CASE_ADD_PLE;
        else if (prod_larger)
            case_o = near ? CASE_SUB_PNEAR : CASE_SUB_PFAR;
        else
            case_o = near ? CASE_SUB_CNEAR : CASE_SUB_CFAR;
    end
endmodule

// File: rtl/fmaal_rshift.sv
module fmaal_rshift #(
    parameter int MW  = 53,
    parameter int SHW = 7
) (
    input  logic [MW-1:0]   op,
    input  logic [SHW-1:0]  shamt,
    output logic [2*MW-1:0] span,
    output logic            lost
);
    localparam int SPAN = 2 * MW;
    localparam int EXTW = 3 * MW;

    logic [EXTW-1:0] ext;

    always_comb begin
        ext  = {op, {SPAN{1'b0}}} >> shamt;
        span = ext[EXTW-1:MW];
        lost = |ext[MW-1:0];
    end
endmodule

// File: rtl/fmaal_round.sv
module fmaal_round #(
    parameter int MW  = 53,
    parameter int SHW = 7
) (
    input  logic            prod_larger,
    input  logic [SHW-1:0]  side_shamt,
    input  logic [2*MW-1:0] span_sum,
    input  logic [2*MW-1:0] span_carry,
    input  logic [2*MW-1:0] span_addend,
    input  logic            lost_any,
    input  logic [1:0]      mul_rnd,
    output logic            sticky,
    output logic [2*MW-1:0] round_term
);
    localparam int SPAN = 2 * MW;

    logic [SHW-1:0]  cp;
    logic [SPAN-1:0] mask;
    logic [SPAN-1:0] rnd_w;

    always_comb begin
        if (prod_larger)
            cp = SHW'(MW);
        else if (side_shamt >= SHW'(MW))
            cp = '0;
        else
            cp = SHW'(MW) - side_shamt;
    end

    for (genvar gi = 0; gi < SPAN; gi++) begin : g_mask
        assign mask[gi] = (int'(cp) > gi);
    end

    always_comb begin
        rnd_w      = {{(SPAN-2){1'b0}}, mul_rnd};
        round_term = rnd_w << cp;
        sticky     = (|(mask & (span_sum | span_carry | span_addend))) | lost_any;
    end
endmodule

// File: rtl/fma_align_unit.sv
module fma_align_unit
    import fmaal_pkg::*;
#(
    parameter int MW        = 53,
    parameter int EW        = 11,
    parameter int CLOSE_THR = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            fused_mode,
    input  logic            eff_sub,
    input  logic [EW-1:0]   exp_prod,
    input  logic [EW-1:0]   exp_addend,
    input  logic [MW-1:0]   sum_vec,
    input  logic [MW-1:0]   carry_vec,
    input  logic [MW-1:0]   addend_c,
    input  logic [MW-1:0]   addend_d,
    input  logic [1:0]      mul_rnd,
    output logic            out_valid,
    output logic [2:0]      case_code,
    output logic [2*MW-1:0] term_sum,
    output logic [2*MW-1:0] term_carry,
    output logic [2*MW-1:0] term_addend,
    output logic [2*MW-1:0] term_round,
    output logic            sticky
);
    localparam int SPAN  = 2 * MW;
    localparam int SHW   = $clog2(SPAN + 1);
    localparam int NLANE = 3;

    align_case_e    cls_case;
    logic           cls_pl;
    logic           cls_near;
    logic [SHW-1:0] cls_shamt;

    fmaal_classify #(.EW(EW), .MW(MW), .CLOSE_THR(CLOSE_THR), .SHW(SHW)) u_cls (
        .eff_sub    (eff_sub),
        .exp_prod   (exp_prod),
        .exp_addend (exp_addend),
        .case_o     (cls_case),
        .prod_larger(cls_pl),
        .near       (cls_near),
        .shamt      (cls_shamt)
    );

    // lane 0: sum (or d), lane 1: carry (zero in add mode), lane 2: addend
    logic [MW-1:0]   op_arr   [NLANE];
    logic [SHW-1:0]  sh_arr   [NLANE];
    logic [SPAN-1:0] span_arr [NLANE];
    logic            lost_arr [NLANE];
    logic [SHW-1:0]  sh_side;
    logic [SHW-1:0]  sh_add;

    always_comb begin
        sh_side   = cls_pl ? '0 : cls_shamt;
        sh_add    = cls_pl ? cls_shamt : '0;
        op_arr[0] = fused_mode ? sum_vec : addend_d;
        op_arr[1] = fused_mode ? carry_vec : '0;
        op_arr[2] = addend_c;
        sh_arr[0] = sh_side;
        sh_arr[1] = sh_side;
        sh_arr[2] = sh_add;
    end

    for (genvar gl = 0; gl < NLANE; gl++) begin : g_lane
        fmaal_rshift #(.MW(MW), .SHW(SHW)) u_sh (
            .op   (op_arr[gl]),
            .shamt(sh_arr[gl]),
            .span (span_arr[gl]),
            .lost (lost_arr[gl])
        );
    end

    // near path: addend moves by 0..2 through a small mux
    logic [SPAN-1:0] near_add;
    logic [SPAN-1:0] add_sel;

    always_comb begin
        unique case (cls_shamt)
            SHW'(0): near_add = {addend_c, {MW{1'b0}}};
            SHW'(1): near_add = {1'b0, addend_c, {(MW-1){1'b0}}};
            default: near_add = {2'b00, addend_c, {(MW-2){1'b0}}};
        endcase
        add_sel = (cls_pl && cls_near) ? near_add : span_arr[2];
    end

    logic            rnd_sticky;
    logic [SPAN-1:0] rnd_term;

    fmaal_round #(.MW(MW), .SHW(SHW)) u_rnd (
        .prod_larger(cls_pl),
        .side_shamt (sh_side),
        .span_sum   (span_arr[0]),
        .span_carry (span_arr[1]),
        .span_addend(add_sel),
        .lost_any   (lost_arr[0] | lost_arr[1] | lost_arr[2]),
        .mul_rnd    (mul_rnd),
        .sticky     (rnd_sticky),
        .round_term (rnd_term)
    );

    logic            inv_side;
    logic            inv_add;
    logic [SPAN-1:0] nx_sum;
    logic [SPAN-1:0] nx_carry;
    logic [SPAN-1:0] nx_add;

    always_comb begin
        inv_side = eff_sub && !cls_pl;
        inv_add  = eff_sub && cls_pl;
        nx_sum   = inv_side ? ~span_arr[0] : span_arr[0];
        nx_carry = !fused_mode ? '0 : (inv_side ? ~span_arr[1] : span_arr[1]);
        nx_add   = inv_add ? ~add_sel : add_sel;
    end

    out_state_e state_q;
    out_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = in_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            case_code   <= 3'd0;
            term_sum    <= '0;
            term_carry  <= '0;
            term_addend <= '0;
            term_round  <= '0;
            sticky      <= 1'b0;
        end else if (in_valid) begin
            case_code   <= cls_case;
            term_sum    <= nx_sum;
            term_carry  <= nx_carry;
            term_addend <= nx_add;
            term_round  <= rnd_term;
            sticky      <= rnd_sticky;
        end
    end

    assign out_valid = (state_q == ST_HOLD);

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_CASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (case_code >= 3'd1 && case_code <= 3'd6)); // R2
    AST_NEAR_SHIFT_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls_near) |-> (cls_shamt <= SHW'(CLOSE_THR))); // R2
    AST_ROUND_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(term_round) <= 2)); // R6
    AST_ADD_MODE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fused_mode) |=> (term_carry == '0)); // R8
endmodule

// File: tb/fma_align_unit_bench.sv
module fma_align_unit_bench;
    localparam int MW   = 6;
    localparam int EW   = 4;
    localparam int SPAN = 2 * MW;
    localparam longint SMASK = (longint'(1) << SPAN) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            fused_mode = 1'b0;
    logic            eff_sub = 1'b0;
    logic [EW-1:0]   exp_prod = '0;
    logic [EW-1:0]   exp_addend = '0;
    logic [MW-1:0]   sum_vec = '0;
    logic [MW-1:0]   carry_vec = '0;
    logic [MW-1:0]   addend_c = '0;
    logic [MW-1:0]   addend_d = '0;
    logic [1:0]      mul_rnd = '0;
    logic            out_valid;
    logic [2:0]      case_code;
    logic [SPAN-1:0] term_sum, term_carry, term_addend, term_round;
    logic            sticky;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    fma_align_unit #(.MW(MW), .EW(EW)) u_fma_align_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fused_mode(fused_mode),
        .eff_sub(eff_sub), .exp_prod(exp_prod), .exp_addend(exp_addend),
        .sum_vec(sum_vec), .carry_vec(carry_vec), .addend_c(addend_c),
        .addend_d(addend_d), .mul_rnd(mul_rnd), .out_valid(out_valid),
        .case_code(case_code), .term_sum(term_sum), .term_carry(term_carry),
        .term_addend(term_addend), .term_round(term_round), .sticky(sticky)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic align(input longint op, input int sh, output longint span, output bit lost);
        longint ext;
        ext  = (op << SPAN) >> sh;
        span = (ext >> MW) & SMASK;
        lost = (ext & ((longint'(1) << MW) - 1)) != 0;
    endtask

    task automatic run_vec(input bit fm, input bit sub, input int ep, input int ea,
                           input int s, input int c, input int a, input int d, input int r);
        int diff, mag, sh, cp, ecase;
        bit pl, ls, lc, la, estk;
        longint sps, spc, spa, es, ec, ea_t, er;
        string rq;
        diff = ep - ea;
        pl   = diff > 0;
        mag  = pl ? diff : -diff;
        sh   = (mag > SPAN) ? SPAN : mag;
        align(fm ? longint'(s) : longint'(d), pl ? 0 : sh, sps, ls);
        align(fm ? longint'(c) : 0, pl ? 0 : sh, spc, lc);
        align(longint'(a), pl ? sh : 0, spa, la);
        if (!sub) ecase = pl ? 1 : 2;
        else if (pl) ecase = (mag <= 2) ? 3 : 4;
        else ecase = (mag <= 2) ? 5 : 6;
        cp   = pl ? MW : ((sh >= MW) ? 0 : MW - sh);
        estk = (((sps | spc | spa) & ((longint'(1) << cp) - 1)) != 0) || ls || lc || la;
        er   = longint'(r) << cp;
        es   = (sub && !pl) ? (~sps & SMASK) : sps;
        ec   = !fm ? 0 : ((sub && !pl) ? (~spc & SMASK) : spc);
        ea_t = (sub && pl) ? (~spa & SMASK) : spa;

        @(negedge clk);
        in_valid = 1; fused_mode = fm; eff_sub = sub;
        exp_prod = EW'(ep); exp_addend = EW'(ea);
        sum_vec = MW'(s); carry_vec = MW'(c); addend_c = MW'(a); addend_d = MW'(d);
        mul_rnd = 2'(r);
        @(negedge clk);
        check(out_valid == 1'b1, "R1", longint'(out_valid), 1);
        check(int'(case_code) == ecase, "R2", longint'(case_code), longint'(ecase));
        rq = sub ? "R5" : (pl ? "R3" : "R4");
        check(longint'(term_sum) == es, fm ? rq : "R8", longint'(term_sum), es);
        check(longint'(term_carry) == ec, fm ? rq : "R8", longint'(term_carry), ec);
        check(longint'(term_addend) == ea_t, (mag > SPAN) ? "R10" : rq, longint'(term_addend), ea_t);
        check(longint'(term_round) == er, "R6", longint'(term_round), er);
        check(sticky == estk, (mag > SPAN) ? "R10" : "R7", longint'(sticky), longint'(estk));
    endtask

    initial begin
        longint keep_sum, keep_add;
        bit     keep_stk;
        repeat (3) @(negedge clk);
        check(out_valid == 0 && case_code == 0 && term_sum == 0 && term_round == 0 && sticky == 0,
              "R1", longint'(out_valid), 0);
        rst_n = 1;
        for (int fm = 0; fm < 2; fm++)
            for (int sub = 0; sub < 2; sub++)
                for (int ep = 0; ep < 16; ep++)
                    for (int ea = 0; ea < 16; ea++) begin
                        int k;
                        k = ((fm * 2 + sub) * 16 + ep) * 16 + ea;
                        run_vec(fm[0], sub[0], ep, ea, (k * 37 + 5) & 63, (k * 11 + 9) & 63,
                                (k * 23 + 1) & 63, (k * 13 + 7) & 63, k % 4);
                    end
        // R9: fused vector repeated with a different addend_d
        run_vec(1'b1, 1'b1, 3, 9, 45, 18, 33, 0, 3);
        keep_sum = longint'(term_sum); keep_add = longint'(term_addend); keep_stk = sticky;
        run_vec(1'b1, 1'b1, 3, 9, 45, 18, 33, 63, 3);
        check(longint'(term_sum) == keep_sum && longint'(term_addend) == keep_add && sticky == keep_stk,
              "R9", longint'(term_sum), keep_sum);
        // R1: valid drops, data held
        @(negedge clk);
        in_valid = 0; addend_c = '0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", longint'(out_valid), 0);
        check(longint'(term_addend) == keep_add, "R1", longint'(term_addend), keep_add);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule